// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Datapath

This block is a 32-bit processor datapath that completes one instruction per clock. A program counter addresses a private instruction memory. The fetched word is decoded into control signals that steer a two-read, one-write register file, an arithmetic/logic unit, a separate data memory and the multiplexers between them. It executes five register-to-register operations (add, subtract, and, or, signed set-less-than), a word load, a word store and a branch taken when two registers are equal.

For test, the instruction memory and the data memory are filled through one preload port while reset is held. After reset is released the core runs from address 0. A testbench watches its progress through the current program counter and two combinational debug read ports, one for the register file and one for the data memory.

Top module: `lsr_core`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is sampled high at a rising edge, the program counter becomes 0, all 32 registers become 0, and no instruction modifies a register or the data memory.
- R2: While `rst` is high, a rising edge with `ld_we` high writes `ld_data` to word `ld_addr` of the instruction memory when `ld_sel` is 0, or of the data memory when `ld_sel` is 1. When `rst` is low, the preload port has no effect on either memory.
- R3: The instruction is fetched from the instruction memory word indexed by PC bits [7:2] (default depth 64). Higher PC bits are ignored for the fetch. Unless a branch is taken, the PC advances by 4 on every rising edge out of reset.
- R4: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0] and immediate [15:0]. Opcode 0x00 with shift amount 0 writes rd with rs+rt (function 0x20), rs−rt (0x22), rs AND rt (0x24), rs OR rt (0x25), or 1/0 for signed rs<rt (0x2A).
- R5: Opcode 0x23 (load word) writes rt with the data memory word at address rs + sign-extended immediate. The word index is address bits [7:2], and the other address bits are ignored.
- R6: Opcode 0x2B (store word) writes the value of rt to the data memory word at the same address as a load would use, and it writes no register.
- R7: Opcode 0x04 (branch if equal) sets the next PC to PC+4 + (sign-extended immediate shifted left by 2) when rs equals rt. Otherwise the next PC is PC+4. It writes no register or memory.
- R8: Register 0 always reads as 0, and writes to it are discarded.
- R9: Any other opcode, and opcode 0x00 with a nonzero shift amount or a function code not listed in R4, changes no register and no memory word. The PC still advances by 4.
- R10: `pc_out` shows the current PC. `dbg_reg_data` and `dbg_mem_data` show, without delay, register `dbg_reg_sel` and data memory word `dbg_mem_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the preload port |
| ld_we | input | 1 | Preload write enable |
| ld_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_reg_sel | input | 5 | Register selected for observation |
| dbg_mem_sel | input | 6 | Data memory word selected for observation |
| pc_out | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_data | output | 32 | Contents of the selected data memory word |

## Verification
A wrong next-PC choice, whether a missed or false branch, a bad target or a broken increment, shows on `pc_out` one edge after the faulty instruction, and every later PC comparison then diverges. A wrong ALU result, write-back selection or destination index leaves a register or memory word different from the independent instruction model. That difference is visible at the debug ports as soon as the word is written, and the bench scans one register and one memory word every cycle while the program runs. Corrupted values also spread through later loads, stores and branch decisions, so many faults show up on `pc_out` within a few instructions.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    known;      // instruction recognised
    logic    reg_write;  // register file write
    logic    dst_rt;     // destination is rt instead of rd
    logic    use_imm;    // ALU operand B from extended immediate
    logic    wb_mem;     // write back the data memory read value
    logic    mem_write;  // data memory store
    logic    branch;     // conditional branch on equality
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] pc,
                                                 input logic [XLEN-1:0] disp);
    return seq_pc(pc) + {disp[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        if (shamt == 5'd0) begin
          case (funct)
            FN_ADD: begin ctl.known = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_ADD; end
            FN_SUB: begin ctl.known = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_SUB; end
            FN_AND: begin ctl.known = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_AND; end
            FN_OR:  begin ctl.known = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_OR;  end
            FN_SLT: begin ctl.known = 1'b1; ctl.reg_write = 1'b1; ctl.alu_op = ALU_SLT; end
            default: ;
          endcase
        end
      end
      OPC_LOAD: begin
        ctl.known     = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.dst_rt    = 1'b1;
        ctl.use_imm   = 1'b1;
        ctl.wb_mem    = 1'b1;
      end
      OPC_STORE: begin
        ctl.known     = 1'b1;
        ctl.use_imm   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctl.known  = 1'b1;
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
  parameter int NUM = 32,
  parameter int W   = 32,
  localparam int AW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_dbg,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
    return (a == '0) ? '0 : regs[a];
  endfunction

  assign rd_a   = rd_port(ra_a);
  assign rd_b   = rd_port(ra_b);
  assign rd_dbg = rd_port(ra_dbg);

endmodule

// File: rtl/lsr_mem.sv
module lsr_mem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/lsr_core.sv
module lsr_core
  import lsr_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [RAW-1:0]  dbg_reg_sel,
  input  logic [DAW-1:0]  dbg_mem_sel,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] dbg_reg_data,
  output logic [XLEN-1:0] dbg_mem_data
);

  // fetch
  logic [XLEN-1:0]          pc_q;
  logic [XLEN-1:0]          pc_next;
  logic [XLEN-1:0]          pc_plus4;
  logic [XLEN-1:0]          br_target;
  logic [XLEN-1:0]          instr;
  logic [0:0][IAW-1:0]      im_raddr;
  logic [0:0][XLEN-1:0]     im_rdata;
  logic                     im_we;

  // decode
  logic [5:0]               opcode;
  logic [RAW-1:0]           rs_idx;
  logic [RAW-1:0]           rt_idx;
  logic [RAW-1:0]           rd_idx;
  logic [4:0]               shamt;
  logic [5:0]               funct;
  logic [XLEN-1:0]          imm_ext;
  ctrl_t                    ctl;
  logic                     dec_known;

  // execute / memory / write-back
  logic [XLEN-1:0]          rs_data;
  logic [XLEN-1:0]          rt_data;
  logic [XLEN-1:0]          alu_b;
  logic [XLEN-1:0]          alu_res;
  logic                     alu_zero;
  logic                     take_branch;
  logic                     rf_we;
  logic [RAW-1:0]           wb_idx;
  logic [XLEN-1:0]          wb_data;
  logic                     dm_we_core;
  logic                     dm_we;
  logic [DAW-1:0]           dm_word;
  logic [DAW-1:0]           dm_waddr;
  logic [XLEN-1:0]          dm_wdata;
  logic [1:0][DAW-1:0]      dm_raddr;
  logic [1:0][XLEN-1:0]     dm_rdata;

  // ---------------- program counter and instruction memory
  assign pc_plus4  = seq_pc(pc_q);
  assign br_target = rel_target(pc_q, imm_ext);
  assign pc_next   = take_branch ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign im_we       = rst && ld_we && !ld_sel;
  assign im_raddr[0] = pc_q[IAW+1:2];

  lsr_mem #(.WORDS(IMEM_WORDS), .W(XLEN), .NRD(1)) u_imem (
    .clk   (clk),
    .we    (im_we),
    .waddr (ld_addr[IAW-1:0]),
    .wdata (ld_data),
    .raddr (im_raddr),
    .rdata (im_rdata)
  );

  assign instr = im_rdata[0];

  // ---------------- decode
  assign opcode  = instr[31:26];
  assign rs_idx  = instr[25:21];
  assign rt_idx  = instr[20:16];
  assign rd_idx  = instr[15:11];
  assign shamt   = instr[10:6];
  assign funct   = instr[5:0];
  assign imm_ext = sext16(instr[15:0]);

  lsr_ctrl u_ctrl (
    .opcode (opcode),
    .shamt  (shamt),
    .funct  (funct),
    .ctl    (ctl)
  );

  assign dec_known = ctl.known;

  // ---------------- register file
  assign rf_we  = !rst && ctl.reg_write;
  assign wb_idx = ctl.dst_rt ? rt_idx : rd_idx;

  lsr_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra_a   (rs_idx),
    .ra_b   (rt_idx),
    .ra_dbg (dbg_reg_sel),
    .rd_a   (rs_data),
    .rd_b   (rt_data),
    .rd_dbg (dbg_reg_data),
    .we     (rf_we),
    .wa     (wb_idx),
    .wd     (wb_data)
  );

  // ---------------- ALU
  assign alu_b    = ctl.use_imm ? imm_ext : rt_data;
  assign alu_res  = alu_eval(ctl.alu_op, rs_data, alu_b);
  assign alu_zero = (alu_res == '0);

  assign take_branch = !rst && ctl.branch && alu_zero;

  // ---------------- data memory (preload port shares the write side in reset)
  assign dm_word    = alu_res[DAW+1:2];
  assign dm_we_core = !rst && ctl.mem_write;
  assign dm_we      = rst ? (ld_we && ld_sel) : ctl.mem_write;
  assign dm_waddr   = rst ? ld_addr[DAW-1:0] : dm_word;
  assign dm_wdata   = rst ? ld_data : rt_data;
  assign dm_raddr[0] = dm_word;
  assign dm_raddr[1] = dbg_mem_sel;

  lsr_mem #(.WORDS(DMEM_WORDS), .W(XLEN), .NRD(2)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (dm_raddr),
    .rdata (dm_rdata)
  );

  assign dbg_mem_data = dm_rdata[1];

  // ---------------- write-back select
  assign wb_data = ctl.wb_mem ? dm_rdata[0] : alu_res;

  assign pc_out = pc_q;

endmodule

// File: rtl/lsr_core_chk.sv
module lsr_core_chk
  import lsr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_q,
  input logic            take_branch,
  input logic [XLEN-1:0] br_target,
  input logic [RAW-1:0]  rs_idx,
  input logic [RAW-1:0]  rt_idx,
  input logic [XLEN-1:0] rs_data,
  input logic [XLEN-1:0] rt_data,
  input logic            rf_we,
  input logic            dm_we_core,
  input logic            dec_known
);

  // R1: first cycle after reset starts at address 0
  a_r1_pc_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc_q == '0);

  // R3: sequential advance by one word
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    !take_branch |=> pc_q == $past(pc_q) + 32'd4);

  // R7: taken branch lands on the computed target
  a_r7_branch_lands: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> pc_q == $past(br_target));

  // R8: register 0 reads as zero on both operand ports
  a_r8_zero_rs: assert property (@(posedge clk) disable iff (rst)
    rs_idx == '0 |-> rs_data == '0);
  a_r8_zero_rt: assert property (@(posedge clk) disable iff (rst)
    rt_idx == '0 |-> rt_data == '0);

  // R6: a store never writes a register
  a_r6_store_no_reg: assert property (@(posedge clk) disable iff (rst)
    dm_we_core |-> !rf_we);

  // R9: unrecognised encodings have no side effect
  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !dec_known |-> !rf_we && !dm_we_core && !take_branch);

  // R4/R5/R6/R7: at most one kind of state update per instruction
  a_r4_one_effect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, dm_we_core, take_branch}));

endmodule

bind lsr_core lsr_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_q        (pc_q),
  .take_branch (take_branch),
  .br_target   (br_target),
  .rs_idx      (rs_idx),
  .rt_idx      (rt_idx),
  .rs_data     (rs_data),
  .rt_data     (rt_data),
  .rf_we       (rf_we),
  .dm_we_core  (dm_we_core),
  .dec_known   (dec_known)
);

// File: tb/test_lsr_core.sv
module test_lsr_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [5:0]  dbg_mem_sel = '0;
  logic [31:0] pc_out;
  logic [31:0] dbg_reg_data;
  logic [31:0] dbg_mem_data;

  lsr_core i_lsr_core (
    .clk          (clk),
    .rst          (rst),
    .ld_we        (ld_we),
    .ld_sel       (ld_sel),
    .ld_addr      (ld_addr),
    .ld_data      (ld_data),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_mem_sel  (dbg_mem_sel),
    .pc_out       (pc_out),
    .dbg_reg_data (dbg_reg_data),
    .dbg_mem_data (dbg_mem_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  logic [31:0] prog  [64];
  logic [31:0] dinit [64];
  logic [31:0] m_rf  [32];
  logic [31:0] m_dm  [64];
  logic [31:0] m_pc;

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finish_up();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // independent instruction-level model
  task automatic model_wr(input logic [4:0] idx, input logic [31:0] v);
    if (idx != 5'd0) m_rf[idx] = v;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, se, addr, nxt;
    ins  = prog[m_pc[7:2]];
    a    = m_rf[ins[25:21]];
    b    = m_rf[ins[20:16]];
    se   = {{16{ins[15]}}, ins[15:0]};
    addr = a + se;
    nxt  = m_pc + 32'd4;
    case (ins[31:26])
      6'h00: if (ins[10:6] == 5'd0) begin
        case (ins[5:0])
          6'h20: model_wr(ins[15:11], a + b);
          6'h22: model_wr(ins[15:11], a - b);
          6'h24: model_wr(ins[15:11], a & b);
          6'h25: model_wr(ins[15:11], a | b);
          6'h2A: model_wr(ins[15:11], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
          default: ;
        endcase
      end
      6'h23: model_wr(ins[20:16], m_dm[addr[7:2]]);
      6'h2B: m_dm[addr[7:2]] = b;
      6'h04: if (a == b) nxt = m_pc + 32'd4 + (se << 2);
      default: ;
    endcase
    m_pc = nxt;
  endtask

  // preload both memories under reset, check reset state, then release
  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 6'(i); ld_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 6'(i); ld_data = dinit[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    chk("R1", "pc in reset", pc_out, 32'd0);
    for (int i = 0; i < 32; i += 7) begin
      dbg_reg_sel = 5'(i);
      #1;
      chk("R1", "register cleared", dbg_reg_data, 32'd0);
    end
    dbg_mem_sel = 6'd4;
    #1;
    chk("R2", "preloaded data word", dbg_mem_data, dinit[4]);
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < 64; i++) m_dm[i] = dinit[i];
    m_pc = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // run n instructions; each cycle compare the PC and one register and word
  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      dbg_reg_sel = 5'(c % 32);
      dbg_mem_sel = 6'(c % 64);
      #1;
      chk("R3", "pc trace", pc_out, m_pc);
      chk("R10", "register scan", dbg_reg_data, m_rf[c % 32]);
      chk("R10", "memory scan", dbg_mem_data, m_dm[c % 64]);
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    dbg_reg_sel = 5'(r);
    #1;
    v = dbg_reg_data;
  endtask

  function automatic logic [31:0] rand_instr();
    logic [5:0] fns [5];
    int k;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    k = $urandom % 10;
    case (k)
      0, 1, 2, 3, 4:
        return enc_r($urandom % 32, $urandom % 32, $urandom % 32, fns[$urandom % 5]);
      5: return enc_i(6'h23, $urandom % 32, $urandom % 32, 16'($urandom));
      6: return enc_i(6'h2B, $urandom % 32, $urandom % 32, 16'($urandom));
      7: return enc_i(6'h04, $urandom % 3, $urandom % 3, 16'(int'($urandom % 13) - 6));
      8: return enc_r($urandom % 32, $urandom % 32, $urandom % 32, 6'($urandom)) |
                {21'd0, 5'(($urandom % 3)), 6'd0};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));

    // ---------------- directed program
    for (int i = 0; i < 64; i++) begin
      prog[i]  = 32'd0;
      dinit[i] = $urandom;
    end
    dinit[0] = 32'd5;
    dinit[1] = 32'hFFFF_FFFD;
    dinit[2] = 32'h0F0F_00FF;
    dinit[3] = 32'h00FF_0FF0;
    dinit[4] = 32'd40;
    prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
    prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(2, 1, 4, 6'h22);
    prog[4]  = enc_r(2, 1, 5, 6'h2A);
    prog[5]  = enc_r(1, 2, 6, 6'h2A);
    prog[6]  = enc_i(6'h23, 0, 7, 16'd8);
    prog[7]  = enc_i(6'h23, 0, 8, 16'd12);
    prog[8]  = enc_r(7, 8, 9, 6'h24);
    prog[9]  = enc_r(7, 8, 10, 6'h25);
    prog[10] = enc_r(1, 1, 0, 6'h20);
    prog[11] = enc_i(6'h23, 0, 11, 16'd16);
    prog[12] = enc_i(6'h2B, 11, 4, 16'hFFF8);
    prog[13] = enc_i(6'h23, 11, 12, 16'hFFF8);
    prog[14] = enc_i(6'h04, 1, 2, 16'd5);
    prog[15] = enc_i(6'h04, 5, 5, 16'd2);
    prog[16] = enc_r(1, 1, 13, 6'h20);
    prog[17] = enc_r(1, 1, 13, 6'h20);
    prog[18] = enc_r(1, 1, 14, 6'h20);
    prog[19] = enc_r(1, 1, 15, 6'h20) | 32'h0000_0040;
    prog[20] = 32'hFFFF_FFFF;
    prog[21] = enc_i(6'h04, 0, 0, 16'hFFFF);

    load_and_start();
    run(30);

    chk("R7", "self loop pc", pc_out, 32'd84);
    read_reg(1, v);  chk("R5", "load r1", v, 32'd5);
    read_reg(3, v);  chk("R4", "add r3", v, 32'd2);
    read_reg(4, v);  chk("R4", "sub r4", v, 32'hFFFF_FFF8);
    read_reg(5, v);  chk("R4", "slt signed true r5", v, 32'd1);
    read_reg(6, v);  chk("R4", "slt signed false r6", v, 32'd0);
    read_reg(9, v);  chk("R4", "and r9", v, 32'h000F_00F0);
    read_reg(10, v); chk("R4", "or r10", v, 32'h0FFF_0FFF);
    read_reg(0, v);  chk("R8", "r0 after write", v, 32'd0);
    read_reg(12, v); chk("R5", "load negative offset r12", v, 32'hFFFF_FFF8);
    read_reg(13, v); chk("R7", "skipped by branch r13", v, 32'd0);
    read_reg(14, v); chk("R7", "branch target executed r14", v, 32'd10);
    read_reg(15, v); chk("R9", "nonzero shift amount r15", v, 32'd0);
    dbg_mem_sel = 6'd8;
    #1;
    chk("R6", "store word 8", dbg_mem_data, 32'hFFFF_FFF8);

    // R2: preload port ignored outside reset
    @(negedge clk);
    ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 6'd0; ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ld_sel = 1'b0; ld_addr = 6'd21; ld_data = enc_r(1, 1, 16, 6'h20);
    @(negedge clk);
    ld_we = 1'b0;
    repeat (4) @(negedge clk);
    dbg_mem_sel = 6'd0;
    #1;
    chk("R2", "data word untouched", dbg_mem_data, 32'd5);
    read_reg(16, v); chk("R2", "instruction word untouched r16", v, 32'd0);
    chk("R2", "pc still in loop", pc_out, 32'd84);

    // ---------------- constrained random programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 64; i++) begin
        prog[i]  = rand_instr();
        dinit[i] = (i % 5 == 0) ? 32'(i * 4) : $urandom;
      end
      load_and_start();
      run(180);
    end

    finish_up();
  end

endmodule